// File: doc/BRIEF.md
# Floating-Point Compare to Condition Field

This block compares two IEEE-754 double-precision operands and reduces the outcome to a one-hot 4-bit relation code. It writes that code to two places. The first is a chosen 4-bit field of a 32-bit condition register. The second is the condition-code bits of the floating-point status word. Both of these are held inside the block.

Two compare flavours exist. The unordered flavour reports a NaN operand as "unordered". The ordered flavour treats a NaN operand as an invalid operation: it raises a trap pulse and leaves all held state untouched. A malformed destination specifier, or an extended opcode that names neither flavour, raises an illegal pulse and also changes nothing.

Each request is a single-cycle valid strobe. The result is registered and appears one clock later, together with a done pulse. Signalling and quiet NaNs are not told apart.

Top module: `fcmp_cond_unit`

## Requirements
- R1: The relation code is one-hot: less-than 4'b1000, greater-than 4'b0100, equal 4'b0010, unordered 4'b0001. A request strobed on `in_valid` at one rising edge is reflected on the outputs after that edge, with `done` high for exactly that one cycle.
- R2: An operand is a NaN when its exponent bits [62:52] are all ones and its fraction [51:0] is nonzero. If either operand is a NaN, the unordered compare yields 4'b0001.
- R3: `ext_op` 0 selects the unordered compare and 32 selects the ordered compare. Any other value pulses `illegal` and leaves `cr_q` and `fpcc_q` unchanged.
- R4: In the ordered compare, a NaN operand pulses `trap` and leaves `cr_q` and `fpcc_q` unchanged.
- R5: A legal, non-trapping compare replaces condition-register field d, which is bits [31-4d : 28-4d]. All other bits of `cr_q` are kept.
- R6: The same code goes to status bits 14:11, which are `fpcc_q[3:0]`. Status bit 15, which is `fpcc_q[4]`, is cleared.
- R7: `dest_spec[4:2]` gives the field number d. A nonzero `dest_spec[1:0]` pulses `illegal` and changes no state.
- R8: Ordering follows sign-magnitude rules on the bit patterns, subnormals included. +0 and -0 compare equal.
- R9: Infinities are ordered: -inf is below every finite value, +inf is above it, and each infinity equals itself.
- R10: After reset, `cr_q`, `fpcc_q`, `done`, `trap` and `illegal` are all zero.
- R11: In a cycle without `in_valid`, `done`, `trap` and `illegal` are low and `cr_q` and `fpcc_q` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| opnd_a | input | 64 | First operand (double) |
| opnd_b | input | 64 | Second operand (double) |
| dest_spec | input | 5 | Destination specifier: [4:2] field number, [1:0] must be zero |
| ext_op | input | 10 | Extended opcode: 0 unordered, 32 ordered |
| cr_q | output | 32 | Held condition register |
| fpcc_q | output | 5 | Held status bits 15:11 |
| done | output | 1 | Result pulse, one cycle after the strobe |
| trap | output | 1 | Invalid-operation pulse (ordered compare, NaN operand) |
| illegal | output | 1 | Malformed-request pulse |

## Verification
The bench builds the block with its default parameters: an 11-bit exponent with a 52-bit fraction, and a 32-bit register of eight fields. This makes every field position reachable from the 3-bit field number. The double format also lets the expected relation come from native real comparison on the operand bits. Random operands are biased toward signed zeros, infinities, NaNs, subnormals, equal pairs and sign-flipped pairs. That bias brings the equal, zero-sign and infinity orderings within reach alongside ordinary magnitudes.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
   typedef enum logic [3:0] {
      REL_LT = 4'b1000,
      REL_GT = 4'b0100,
      REL_EQ = 4'b0010,
      REL_UN = 4'b0001
   } rel_t;

   localparam int FIELD_W = 4;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
   input  logic [OP_W-1:0] opnd,
   output logic            is_nan,
   output logic            is_zero,
   output logic            sign,
   output logic [OP_W-2:0] mag
);
   logic [EXP_W-1:0]  expo;
   logic [FRAC_W-1:0] frac;

   assign expo    = opnd[OP_W-2 -: EXP_W];
   assign frac    = opnd[FRAC_W-1:0];
   assign sign    = opnd[OP_W-1];
   assign mag     = opnd[OP_W-2:0];
   assign is_nan  = (&expo) && (|frac);
   assign is_zero = ~|mag;
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
   import fcmp_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
   input  logic [OP_W-1:0] opnd_a,
   input  logic [OP_W-1:0] opnd_b,
   output rel_t            rel,
   output logic            any_nan
);
   logic [1:0]            nan_v, zero_v, sign_v;
   logic [1:0][OP_W-2:0]  mag_v;
   logic [1:0][OP_W-1:0]  opnd_v;

   assign opnd_v[0] = opnd_a;
   assign opnd_v[1] = opnd_b;

   for (genvar g = 0; g < 2; g++) begin : g_cls
      fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .opnd    (opnd_v[g]),
         .is_nan  (nan_v[g]),
         .is_zero (zero_v[g]),
         .sign    (sign_v[g]),
         .mag     (mag_v[g])
      );
   end

   assign any_nan = |nan_v;

   always_comb begin
      if (any_nan)
         rel = REL_UN;
      else if (&zero_v)
         rel = REL_EQ;
      else if (sign_v[0] != sign_v[1])
         rel = sign_v[0] ? REL_LT : REL_GT;
      else if (mag_v[0] == mag_v[1])
         rel = REL_EQ;
      else if ((mag_v[0] < mag_v[1]) ^ sign_v[0])
         rel = REL_LT;
      else
         rel = REL_GT;
   end
endmodule

// File: rtl/fcmp_field_merge.sv
module fcmp_field_merge
   import fcmp_pkg::*;
#(
   parameter int CR_W   = 32,
   parameter int FIDX_W = 3,
   localparam int NFIELD = CR_W / FIELD_W
) (
   input  logic [CR_W-1:0]    cr_cur,
   input  logic [FIDX_W-1:0]  fidx,
   input  logic [FIELD_W-1:0] code,
   output logic [CR_W-1:0]    cr_new
);
   for (genvar g = 0; g < NFIELD; g++) begin : g_fld
      localparam int HI = CR_W - 1 - FIELD_W * g;
      assign cr_new[HI -: FIELD_W] =
         (fidx == FIDX_W'(g)) ? code : cr_cur[HI -: FIELD_W];
   end
endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
   import fcmp_pkg::*;
#(
   parameter int EXP_W    = 11,
   parameter int FRAC_W   = 52,
   parameter int CR_W     = 32,
   parameter int SPEC_W   = 5,
   parameter int XO_W     = 10,
   parameter int XO_UNORD = 0,
   parameter int XO_ORD   = 32,
   localparam int OP_W    = 1 + EXP_W + FRAC_W,
   localparam int FIDX_W  = SPEC_W - 2,
   localparam int NFIELD  = CR_W / FIELD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   opnd_a,
   input  logic [OP_W-1:0]   opnd_b,
   input  logic [SPEC_W-1:0] dest_spec,
   input  logic [XO_W-1:0]   ext_op,
   output logic [CR_W-1:0]   cr_q,
   output logic [FIELD_W:0]  fpcc_q,
   output logic              done,
   output logic              trap,
   output logic              illegal
);
   if (CR_W % FIELD_W != 0) begin : g_bad_cr
      $error("CR_W must be a multiple of the field width");
   end
   if ((1 << FIDX_W) > NFIELD) begin : g_bad_spec
      $error("field number can address beyond the register");
   end
   if (XO_UNORD == XO_ORD) begin : g_bad_xo
      $error("the two compare opcodes must differ");
   end

   rel_t             rel;
   logic             any_nan;
   logic [CR_W-1:0]  cr_next;
   logic             is_unord, is_ord, bad_req, do_trap, do_write;

   fcmp_relate #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rel (
      .opnd_a  (opnd_a),
      .opnd_b  (opnd_b),
      .rel     (rel),
      .any_nan (any_nan)
   );

   fcmp_field_merge #(.CR_W(CR_W), .FIDX_W(FIDX_W)) u_merge (
      .cr_cur (cr_q),
      .fidx   (dest_spec[SPEC_W-1:2]),
      .code   (rel),
      .cr_new (cr_next)
   );

   assign is_unord = (ext_op == XO_W'(XO_UNORD));
   assign is_ord   = (ext_op == XO_W'(XO_ORD));
   assign bad_req  = (|dest_spec[1:0]) || !(is_unord || is_ord);
   assign do_trap  = !bad_req && is_ord && any_nan;
   assign do_write = in_valid && !bad_req && !do_trap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cr_q    <= '0;
         fpcc_q  <= '0;
         done    <= 1'b0;
         trap    <= 1'b0;
         illegal <= 1'b0;
      end else begin
         done    <= in_valid;
         trap    <= in_valid && do_trap;
         illegal <= in_valid && bad_req;
         if (do_write) begin
            cr_q   <= cr_next;
            fpcc_q <= {1'b0, rel};
         end
      end
   end
endmodule

// File: rtl/fcmp_cond_chk.sv
module fcmp_cond_chk #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int CR_W   = 32,
   parameter int SPEC_W = 5,
   parameter int XO_W   = 10,
   localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [OP_W-1:0]   opnd_a,
   input logic [OP_W-1:0]   opnd_b,
   input logic [SPEC_W-1:0] dest_spec,
   input logic [XO_W-1:0]   ext_op,
   input logic [CR_W-1:0]   cr_q,
   input logic [4:0]        fpcc_q,
   input logic              done,
   input logic              trap,
   input logic              illegal
);
   logic nan_in;
   assign nan_in = ((&opnd_a[OP_W-2 -: EXP_W]) && (|opnd_a[FRAC_W-1:0])) ||
                   ((&opnd_b[OP_W-2 -: EXP_W]) && (|opnd_b[FRAC_W-1:0]));

   a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> done);

   a_r1_code_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !trap && !illegal) |-> $onehot(fpcc_q[3:0]));

   a_r2_nan_unordered: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ext_op == '0 && dest_spec[1:0] == 2'b00 && nan_in)
      |=> (fpcc_q[3:0] == 4'b0001));

   a_r3_illegal_holds: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> ($stable(cr_q) && $stable(fpcc_q)));

   a_r4_trap_holds: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> ($stable(cr_q) && $stable(fpcc_q)));

   a_r6_class_clear: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !fpcc_q[4]);

   a_r7_spec_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dest_spec[1:0] != 2'b00) |=> illegal);

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!done && !trap && !illegal && $stable(cr_q) && $stable(fpcc_q)));

   a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({trap, illegal}));
endmodule

bind fcmp_cond_unit fcmp_cond_chk #(
   .EXP_W(EXP_W), .FRAC_W(FRAC_W), .CR_W(CR_W), .SPEC_W(SPEC_W), .XO_W(XO_W)
) u_chk (.*);

// File: tb/sim_fcmp_cond_unit.sv
`timescale 1ns/1ps
module sim_fcmp_cond_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] opnd_a = '0, opnd_b = '0;
   logic [4:0]  dest_spec = '0;
   logic [9:0]  ext_op = '0;
   logic [31:0] cr_q;
   logic [4:0]  fpcc_q;
   logic        done, trap, illegal;

   int total = 0;
   int bad = 0;
   logic [31:0] exp_cr = '0;
   logic [4:0]  exp_cc = '0;

   localparam logic [63:0] PZERO = 64'h0000_0000_0000_0000;
   localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
   localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
   localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
   localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0001;
   localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
   localparam logic [63:0] NTWO  = 64'hC000_0000_0000_0000;
   localparam logic [63:0] MAXF  = 64'h7FEF_FFFF_FFFF_FFFF;
   localparam logic [63:0] SUBN  = 64'h0000_0000_0000_0001;

   always #4 clk = ~clk;

   fcmp_cond_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .dest_spec(dest_spec), .ext_op(ext_op),
      .cr_q(cr_q), .fpcc_q(fpcc_q), .done(done), .trap(trap), .illegal(illegal)
   );

   function automatic logic is_nan(input logic [63:0] v);
      return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
   endfunction

   function automatic logic [3:0] ref_rel(input logic [63:0] a, input logic [63:0] b);
      real ra, rb;
      if (is_nan(a) || is_nan(b)) return 4'b0001;
      ra = $bitstoreal(a);
      rb = $bitstoreal(b);
      if (ra < rb) return 4'b1000;
      if (ra > rb) return 4'b0100;
      return 4'b0010;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, expv);
      end
   endtask

   task automatic run_cmp(input logic [63:0] a, input logic [63:0] b,
                          input logic [4:0] spec, input logic [9:0] xo,
                          input string req);
      logic       illeg, trp;
      logic [3:0] code;
      int         d;
      illeg = (spec[1:0] != 2'b00) || (xo != 10'd0 && xo != 10'd32);
      code  = ref_rel(a, b);
      trp   = !illeg && xo == 10'd32 && code == 4'b0001;
      if (!illeg && !trp) begin
         d = int'(spec[4:2]);
         exp_cr[31 - 4*d -: 4] = code;
         exp_cc = {1'b0, code};
      end
      opnd_a = a; opnd_b = b; dest_spec = spec; ext_op = xo; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk({req, " R1 done"}, 64'(done), 64'(1'b1));
      chk({req, " R4 trap"}, 64'(trap), 64'(trp));
      chk({req, " R3 R7 illegal"}, 64'(illeg), 64'(illegal));
      chk({req, " R5 cr"}, 64'(cr_q), 64'(exp_cr));
      chk({req, " R6 fpcc"}, 64'(fpcc_q), 64'(exp_cc));
      @(negedge clk);
      chk({req, " R11 idle done"}, 64'({done, trap, illegal}), 64'(3'b000));
      chk({req, " R11 idle cr"}, 64'(cr_q), 64'(exp_cr));
   endtask

   function automatic logic [63:0] pick_opnd();
      case ($urandom % 10)
         0: return PZERO;
         1: return NZERO;
         2: return PINF;
         3: return NINF;
         4: return {$urandom % 2 == 0 ? 1'b0 : 1'b1, 11'h7FF, 20'($urandom) | 20'h1, 32'($urandom)};
         5: return {1'b0 ^ 1'($urandom), 11'h000, 20'($urandom), 32'($urandom)};
         default: return {32'($urandom), 32'($urandom)};
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R10 reset cr", 64'(cr_q), 64'd0);
      chk("R10 reset flags", 64'({fpcc_q, done, trap, illegal}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      run_cmp(ONE, NTWO, 5'b000_00, 10'd0, "R1 gt");
      run_cmp(NTWO, ONE, 5'b111_00, 10'd0, "R1 lt");
      run_cmp(PZERO, NZERO, 5'b011_00, 10'd32, "R8 zero eq");
      run_cmp(NZERO, SUBN, 5'b010_00, 10'd0, "R8 subnormal");
      run_cmp(NINF, {1'b1, MAXF[62:0]}, 5'b001_00, 10'd0, "R9 -inf");
      run_cmp(PINF, MAXF, 5'b100_00, 10'd32, "R9 +inf");
      run_cmp(PINF, PINF, 5'b101_00, 10'd0, "R9 inf eq");
      run_cmp(QNAN, ONE, 5'b110_00, 10'd0, "R2 nan a");
      run_cmp(ONE, QNAN | NZERO, 5'b000_00, 10'd0, "R2 nan b");
      run_cmp(QNAN, ONE, 5'b001_00, 10'd32, "R4 ordered nan");
      run_cmp(ONE, NTWO, 5'b010_01, 10'd0, "R7 bad spec");
      run_cmp(ONE, NTWO, 5'b010_10, 10'd32, "R7 bad spec2");
      run_cmp(ONE, NTWO, 5'b010_00, 10'd33, "R3 bad opcode");
      run_cmp(ONE, NTWO, 5'b010_00, 10'd512, "R3 bad opcode2");

      for (int i = 0; i < 3000; i++) begin
         logic [63:0] a, b;
         logic [4:0]  spec;
         logic [9:0]  xo;
         int          r;
         a = pick_opnd();
         case ($urandom % 5)
            0: b = a;
            1: b = a ^ NZERO;
            2: b = a + 64'd1;
            default: b = pick_opnd();
         endcase
         r = $urandom % 20;
         xo = (r < 9) ? 10'd0 : (r < 18) ? 10'd32 : 10'($urandom);
         spec = ($urandom % 8 == 0) ? 5'($urandom) : {3'($urandom), 2'b00};
         run_cmp(a, b, spec, xo, "R5 R8 random");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule